// File: doc/BRIEF.md
# Serial Control Word Receiver

This block takes 24-bit control words from a host microcontroller over a three-wire serial port: a data line, a serial clock and an active-low latch line. All three wires are asynchronous to the system clock. They pass through multi-flop synchronisers, and edges are detected in the system clock domain. On each rising serial-clock edge, one data bit moves into a shift register. While the latch line is low, a holding register follows the shift register. When the latch line rises, the held word is split into a type bit, a 7-bit label and a 16-bit data field, and the block issues a one-cycle processing request.

The type bit selects between two kinds of transfer:

- **Type 0 (DSP-related):** program or coefficient-RAM writes.
- **Type 1 (non-DSP):** mode and mix settings.

A synchronous protect input blocks type-0 requests. A blocked request produces a separate one-cycle pulse instead. The protect input also forces the two mix coefficients to +1 and 0. The coefficients use 8-bit two's-complement gain codes, where 8'h7F means +1 and 8'h80 means −1.

Top module: `serial_ctl_rx`

## Requirements
- R1: After reset, `req_o` and `blocked_o` are 0, `type_o`, `label_o` and `data_o` are 0, `mix0_o` reads 8'h7F and `mix1_o` reads 8'h00.
- R2: The word is shifted on rising serial-clock edges in wire order: type bit first, then label bits 0 to 6, then data bits 0 to 15. The fields of the last 24 bits shifted appear on `type_o`, `label_o` and `data_o` with the request.
- R3: The holding register follows the shift register only while the latch line is low. Bits shifted in before the final 24 do not affect the reported word.
- R4: Each rising edge of the latch line yields exactly one request or blocked pulse, one system cycle wide. Neither the latch falling edge nor serial-clock activity with the latch high yields any pulse.
- R5: Type-1 words raise `req_o` whatever the state of `protect_i`.
- R6: A type-0 word arriving while `protect_i` is 1 does not raise `req_o`. It pulses `blocked_o` once instead. `req_o` and `blocked_o` are never high together.
- R7: A type-1 word whose label equals `MODE_LABEL` (default 7'h00) is a mode transfer. Its `data_o` reads zero.
- R8: A type-1 word with label `MIX0_LABEL` (default 7'h10) or `MIX1_LABEL` (default 7'h11) stores data bits 7:0 as mix coefficient 0 or 1. 8'h7F encodes +1 and 8'h80 encodes −1.
- R9: While `protect_i` is 1, `mix0_o` reads 8'h7F and `mix1_o` reads 8'h00. When protect drops, the stored values reappear in the same cycle.
- R10: If the latch rising edge and an extra serial-clock rising edge reach the system domain in the same cycle, the reported word is the one held before that extra bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data (asynchronous) |
| ser_lat_n_i | input | 1 | Active-low latch (asynchronous) |
| protect_i | input | 1 | Write protect, synchronous to clk |
| req_o | output | 1 | One-cycle processing request |
| blocked_o | output | 1 | One-cycle pulse for a type-0 word suppressed by protect |
| type_o | output | 1 | Type bit of the last word (0 = DSP-related) |
| label_o | output | 7 | Label of the last word |
| data_o | output | 16 | Data of the last word (zero for mode transfers) |
| mix0_o | output | 8 | Mix coefficient 0 |
| mix1_o | output | 8 | Mix coefficient 1 |

## Verification
Two functions can fall in the same cycle: shifting a serial bit and capturing the word at the latch rising edge. The bench provokes this by raising the serial clock and releasing the latch on the same system edge, with a fresh bit on the data line. It then judges that the reported label and data match the word held before that bit. A second coincidence is a mix write while protect is high. Here the outputs must stay forced, and the stored value must appear once protect falls.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int LBL_W   = 7;
  localparam int DAT_W   = 16;
  localparam int FRAME_W = 1 + LBL_W + DAT_W;
  localparam int COEF_W  = 8;

  // Gain codes for 8-bit coefficients
  localparam logic [COEF_W-1:0] COEF_POS_ONE = 8'h7F;
  localparam logic [COEF_W-1:0] COEF_NEG_ONE = 8'h80;
  localparam logic [COEF_W-1:0] COEF_NIL     = 8'h00;

  typedef struct packed {
    logic             non_dsp;
    logic [LBL_W-1:0] lbl;
    logic [DAT_W-1:0] dat;
  } ctl_word_t;

  // Shift register holds the first wire bit at the MSB; fields travel LSB first.
  function automatic ctl_word_t unpack_word(input logic [FRAME_W-1:0] sr);
    ctl_word_t w;
    w.non_dsp = sr[FRAME_W-1];
    for (int i = 0; i < LBL_W; i++) w.lbl[i] = sr[FRAME_W-2-i];
    for (int i = 0; i < DAT_W; i++) w.dat[i] = sr[DAT_W-1-i];
    return w;
  endfunction

  function automatic logic is_mode(input ctl_word_t w, input logic [LBL_W-1:0] mode_lbl);
    return w.non_dsp && (w.lbl == mode_lbl);
  endfunction

  function automatic logic is_blocked(input ctl_word_t w, input logic prot);
    return !w.non_dsp && prot;
  endfunction

  function automatic logic hits_label(input ctl_word_t w, input logic [LBL_W-1:0] lbl);
    return w.non_dsp && (w.lbl == lbl);
  endfunction
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      chain[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev_q <= chain[STAGES-1];
    end
  end

  assign lvl_o = chain[STAGES-1];

  for (genvar b = 0; b < W; b++) begin : g_edge
    assign rise_o[b] = chain[STAGES-1][b] & ~prev_q[b];
  end
endmodule

// File: rtl/sctl_shift.sv
module sctl_shift #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_i,
  output logic [N-1:0] word_o
);
  logic [N-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= {sr_q[N-2:0], bit_i};
  end

  assign word_o = sr_q;

  // R2
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word_o));
endmodule

// File: rtl/sctl_capture.sv
module sctl_capture
  import sctl_pkg::*;
#(
  parameter logic [LBL_W-1:0] MODE_LABEL = 7'h00,
  parameter logic [LBL_W-1:0] MIX0_LABEL = 7'h10,
  parameter logic [LBL_W-1:0] MIX1_LABEL = 7'h11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lat_low,
  input  logic               lat_rise,
  input  logic [FRAME_W-1:0] sr_word,
  input  logic               protect_i,
  output logic               req_o,
  output logic               blocked_o,
  output logic               type_o,
  output logic [LBL_W-1:0]   label_o,
  output logic [DAT_W-1:0]   data_o,
  output logic [COEF_W-1:0]  mix0_o,
  output logic [COEF_W-1:0]  mix1_o
);
  logic [FRAME_W-1:0] hold_q;
  ctl_word_t          held;
  logic               blk;
  logic [COEF_W-1:0]  mix0_q, mix1_q;

  // Transparent while the latch is low; frozen from its rising edge on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (lat_low) hold_q <= sr_word;
  end

  assign held = unpack_word(hold_q);
  assign blk  = is_blocked(held, protect_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o     <= 1'b0;
      blocked_o <= 1'b0;
      type_o    <= 1'b0;
      label_o   <= '0;
      data_o    <= '0;
    end else begin
      req_o     <= lat_rise & ~blk;
      blocked_o <= lat_rise & blk;
      if (lat_rise) begin
        type_o  <= held.non_dsp;
        label_o <= held.lbl;
        data_o  <= is_mode(held, MODE_LABEL) ? '0 : held.dat;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mix0_q <= COEF_POS_ONE;
      mix1_q <= COEF_NIL;
    end else if (lat_rise) begin
      if (hits_label(held, MIX0_LABEL)) mix0_q <= held.dat[COEF_W-1:0];
      if (hits_label(held, MIX1_LABEL)) mix1_q <= held.dat[COEF_W-1:0];
    end
  end

  assign mix0_o = protect_i ? COEF_POS_ONE : mix0_q;
  assign mix1_o = protect_i ? COEF_NIL     : mix1_q;

  // R3
  hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_low |=> $stable(hold_q));
  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);
  // R6
  dsp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (type_o || !$past(protect_i)));
  // R6
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_o && blocked_o));
  // R7
  mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && type_o && label_o == MODE_LABEL) |-> data_o == '0);
  // R8
  mix_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && type_o && label_o == MIX0_LABEL) |-> mix0_q == data_o[COEF_W-1:0]);
endmodule

// File: rtl/serial_ctl_rx.sv
module serial_ctl_rx
  import sctl_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [LBL_W-1:0] MODE_LABEL  = 7'h00,
  parameter logic [LBL_W-1:0] MIX0_LABEL  = 7'h10,
  parameter logic [LBL_W-1:0] MIX1_LABEL  = 7'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_lat_n_i,
  input  logic              protect_i,
  output logic              req_o,
  output logic              blocked_o,
  output logic              type_o,
  output logic [LBL_W-1:0]  label_o,
  output logic [DAT_W-1:0]  data_o,
  output logic [COEF_W-1:0] mix0_o,
  output logic [COEF_W-1:0] mix1_o
);
  localparam int PINS = 3;  // [0] serial clock, [1] data, [2] latch
  localparam logic [PINS-1:0] PIN_IDLE = 3'b100;

  logic [PINS-1:0]    pin_lvl, pin_rise;
  logic [FRAME_W-1:0] sr_word;
  logic               bit_strobe, lat_low, lat_rise;
  logic               unused_sync;

  sctl_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({ser_lat_n_i, ser_dat_i, ser_clk_i}),
    .lvl_o   (pin_lvl),
    .rise_o  (pin_rise)
  );

  assign bit_strobe  = pin_rise[0];
  assign lat_low     = ~pin_lvl[2];
  assign lat_rise    = pin_rise[2];
  assign unused_sync = pin_lvl[0] ^ pin_rise[1];

  sctl_shift #(.N(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (bit_strobe),
    .bit_i    (pin_lvl[1]),
    .word_o   (sr_word)
  );

  sctl_capture #(
    .MODE_LABEL (MODE_LABEL),
    .MIX0_LABEL (MIX0_LABEL),
    .MIX1_LABEL (MIX1_LABEL)
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .lat_low   (lat_low),
    .lat_rise  (lat_rise),
    .sr_word   (sr_word),
    .protect_i (protect_i),
    .req_o     (req_o),
    .blocked_o (blocked_o),
    .type_o    (type_o),
    .label_o   (label_o),
    .data_o    (data_o),
    .mix0_o    (mix0_o),
    .mix1_o    (mix1_o)
  );

  // R4
  no_pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lat_rise) |-> !(req_o || blocked_o));
endmodule

// File: tb/serial_ctl_rx_bench.sv
`timescale 1ns/1ps
module serial_ctl_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_lat_n = 1'b1, protect = 1'b0;
  logic req, blk, typ;
  logic [6:0]  lbl;
  logic [15:0] dat;
  logic [7:0]  mx0, mx1;

  serial_ctl_rx u_serial_ctl_rx (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_lat_n_i(ser_lat_n), .protect_i(protect), .req_o(req), .blocked_o(blk),
    .type_o(typ), .label_o(lbl), .data_o(dat), .mix0_o(mx0), .mix1_o(mx1)
  );

  always #2.5 clk = ~clk;

  int vecs = 0, bad = 0;
  int req_seen = 0, blk_seen = 0;
  logic        cap_t;
  logic [6:0]  cap_l;
  logic [15:0] cap_d;
  logic [7:0]  m0 = 8'h7F, m1 = 8'h00;

  always @(negedge clk) if (rst_n) begin
    if (req) begin req_seen++; cap_t = typ; cap_l = lbl; cap_d = dat; end
    if (blk) blk_seen++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic wire_bit(input logic s, input logic [6:0] l, input logic [15:0] d, input int k);
    if (k == 0) return s;
    if (k < 8)  return l[k-1];
    return d[k-8];
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk); ser_dat = b;
    wait_cyc(3); ser_clk = 1'b1;
    wait_cyc(3); ser_clk = 1'b0;
    wait_cyc(2);
  endtask

  task automatic send_word(input logic s, input logic [6:0] l, input logic [15:0] d);
    for (int k = 0; k < 24; k++) send_bit(wire_bit(s, l, d, k));
  endtask

  task automatic judge(input logic s, input logic [6:0] l, input logic [15:0] d, input logic prot);
    logic [15:0] exp_d;
    if (!s && prot) begin
      chk(req_seen == 0, "R6 request suppressed", req_seen, 0);
      chk(blk_seen == 1, "R6 blocked pulse", blk_seen, 1);
    end else begin
      chk(req_seen == 1, s ? "R5 one request" : "R4 one request", req_seen, 1);
      chk(blk_seen == 0, "R4 no blocked pulse", blk_seen, 0);
      chk(cap_t == s, "R2 type bit", cap_t, s);
      chk(cap_l == l, "R2 label", cap_l, l);
      exp_d = (s && l == 7'h00) ? 16'h0 : d;
      chk(cap_d == exp_d, (s && l == 7'h00) ? "R7 mode data zero" : "R2 data", cap_d, exp_d);
      if (s && l == 7'h10) m0 = d[7:0];
      if (s && l == 7'h11) m1 = d[7:0];
    end
    chk(mx0 == (prot ? 8'h7F : m0), prot ? "R9 mix0 forced" : "R8 mix0", mx0, prot ? 8'h7F : m0);
    chk(mx1 == (prot ? 8'h00 : m1), prot ? "R9 mix1 forced" : "R8 mix1", mx1, prot ? 8'h00 : m1);
  endtask

  task automatic xfer(input logic s, input logic [6:0] l, input logic [15:0] d,
                      input logic prot, input bit early, input int lead);
    @(negedge clk); protect = prot; req_seen = 0; blk_seen = 0;
    if (early) begin ser_lat_n = 1'b0; wait_cyc(4); end
    for (int j = 0; j < lead; j++) send_bit(1'($urandom));
    send_word(s, l, d);
    if (!early) begin wait_cyc(4); ser_lat_n = 1'b0; end
    wait_cyc(6); ser_lat_n = 1'b1;
    wait_cyc(10);
    judge(s, l, d, prot);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    wait_cyc(5); rst_n = 1'b1; wait_cyc(3);
    // R1 reset state
    chk(req == 0 && blk == 0, "R1 pulses idle", {req, blk}, 0);
    chk({typ, lbl, dat} == '0, "R1 fields zero", {typ, lbl, dat}, 0);
    chk(mx0 == 8'h7F, "R1 mix0 reset", mx0, 8'h7F);
    chk(mx1 == 8'h00, "R1 mix1 reset", mx1, 8'h00);

    // R4 serial activity with latch high and no latch edge
    req_seen = 0; blk_seen = 0;
    for (int j = 0; j < 10; j++) send_bit(1'($urandom));
    wait_cyc(8);
    chk(req_seen == 0 && blk_seen == 0, "R4 no pulse without latch", req_seen + blk_seen, 0);

    // Directed words
    xfer(1'b1, 7'h10, 16'hA57F, 1'b0, 1'b0, 0);  // R8 mix0 = +1
    xfer(1'b1, 7'h11, 16'h3C80, 1'b0, 1'b1, 0);  // R8 mix1 = -1
    xfer(1'b1, 7'h00, 16'hBEEF, 1'b0, 1'b0, 0);  // R7 mode transfer
    xfer(1'b0, 7'h55, 16'h1234, 1'b1, 1'b0, 0);  // R6 blocked
    xfer(1'b0, 7'h2A, 16'hF00D, 1'b0, 1'b1, 5);  // R3 leading junk bits
    xfer(1'b1, 7'h10, 16'h0042, 1'b1, 1'b0, 0);  // R5 R9 write under protect

    // R9 protect release shows stored values in the same cycle
    @(negedge clk); protect = 1'b0; #1;
    chk(mx0 == m0, "R9 mix0 after release", mx0, m0);
    chk(mx1 == m1, "R9 mix1 after release", mx1, m1);
    @(negedge clk); protect = 1'b1; #1;
    chk(mx0 == 8'h7F && mx1 == 8'h00, "R9 forced again", {mx0, mx1}, 16'h7F00);
    @(negedge clk); protect = 1'b0;

    // R10 latch release coinciding with an extra serial clock edge
    @(negedge clk); req_seen = 0; blk_seen = 0; ser_lat_n = 1'b0;
    send_word(1'b1, 7'h63, 16'h9A5C);
    wait_cyc(4);
    ser_dat = 1'b1; ser_clk = 1'b1; ser_lat_n = 1'b1;
    wait_cyc(3); ser_clk = 1'b0; wait_cyc(10);
    chk(req_seen == 1, "R10 one request", req_seen, 1);
    chk(cap_l == 7'h63, "R10 label unshifted", cap_l, 7'h63);
    chk(cap_d == 16'h9A5C, "R10 data unshifted", cap_d, 16'h9A5C);

    // Constrained random words
    for (int n = 0; n < 40; n++) begin
      logic [6:0] l;
      int pick;
      pick = int'($urandom_range(0, 5));
      l = (pick == 0) ? 7'h00 : (pick == 1) ? 7'h10 : (pick == 2) ? 7'h11 : 7'($urandom);
      xfer(1'($urandom), l, 16'($urandom), 1'($urandom_range(0, 3) == 0),
           1'($urandom), int'($urandom_range(0, 3)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule